// File: doc/BRIEF.md
# Modular Exponentiation Engine

This block raises a 32-bit message to a 32-bit exponent modulo a 32-bit modulus. It uses right-to-left binary square-and-multiply. Encryption and decryption are the same operation: the caller puts the public or the private exponent on the exponent bus and the message or the ciphertext on the data bus. A single-cycle strobe starts an operation while `ready` is high. The block copies all three buses into internal registers at that edge, so the caller is free to change them afterwards. When `ready` returns high, `result` holds the answer and keeps it until the next operation finishes.

Internally there are two identical serial modular multipliers, called lanes. Each one uses the interleaved shift-add method, taking one multiplier bit per clock, and it subtracts the modulus conditionally after the doubling step and again after the addition. Lane 0 first reduces the message (as message times 1) and then does every squaring of the base. Lane 1 multiplies the running result by the base. Round 0 sets the running result from exponent bit 0. Rounds 1 to 31 then follow with no early exit, so the latency does not depend on the data.

The controller has seven states:
- `ST_IDLE` goes to `ST_RED_GO` on a strobe.
- `ST_RED_GO` goes to `ST_RED_WAIT` after one cycle; it launches the reduction.
- `ST_RED_WAIT` goes to `ST_PRIME_GO` when lane 0 finishes; this is round 0, the seed.
- `ST_PRIME_GO` goes to `ST_PRIME_WAIT` after one cycle.
- `ST_PRIME_WAIT` goes to `ST_ROUND_GO` when lane 0 finishes, which leaves the base equal to the message squared.
- `ST_ROUND_GO` goes to `ST_ROUND_WAIT` after one cycle; it launches both lanes.
- `ST_ROUND_WAIT` goes to `ST_ROUND_GO` when the lanes finish and the round is not the last one. After round 31 it goes to `ST_IDLE` and publishes the result.

Top module: `modexp_engine`

## Requirements
- R1: For any modulus n ≥ 2 and any 32-bit unsigned exponent e and message m, `result` after completion equals m^e mod n. The message may be n or larger.
- R2: With exponent 0, the result is 1.
- R3: With exponent 1, the result is m mod n.
- R4: Exponent bits are consumed from bit 0 (LSB) upward. Bit 0 selects the seed: the reduced message when it is 1, the constant 1 when it is 0. The last round uses bit 31, and an operation always ends after exactly 32 rounds (round indices 0 to 31).
- R5: The number of cycles from the strobe to `ready` high is the same for every operand value. Both lanes finish in the same cycle in each round.
- R6: A strobe sampled while `ready` is 1 starts an operation, and `ready` is 0 from the next cycle until completion. Bus changes after the strobe edge do not affect the result.
- R7: A strobe while `ready` is 0 is ignored. It neither changes the result nor queues another operation.
- R8: Synchronous active-high reset sets `result` to 0 and `ready` to 1, and aborts any operation in progress.
- R9: `result` does not change while an operation is in progress. It changes only at the edge where `ready` returns to 1.
- R10: The accumulator of each multiplier lane stays below the modulus at all times while the lane is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mod_in | input | 32 | Modulus n (≥ 2) |
| exp_in | input | 32 | Exponent, public or private |
| data_in | input | 32 | Message or ciphertext |
| data_strobe | input | 1 | Starts an operation when `ready` is 1 |
| result | output | 32 | Last completed m^e mod n |
| ready | output | 1 | High when idle and able to accept a strobe |

## Verification
Some properties are checked by assertions on every cycle:
- each lane's accumulator stays below the modulus, and no lane is restarted while it is busy;
- `ready` only falls after a strobe;
- `result` holds while the block is busy;
- completion happens only after round 31, and no round is added beyond it;
- the two lanes finish together.

Other behaviour can only be shown by the bench scenarios:
- the arithmetic value itself, for known key pairs, the extreme values of the exponent and the modulus, and random odd moduli checked against a behavioural model;
- that latency does not change across operands;
- that a strobe while busy, or bus changes during an operation, are ignored;
- that a reset in mid-operation aborts it.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

    parameter int MX_WIDTH = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RED_GO,
        ST_RED_WAIT,
        ST_PRIME_GO,
        ST_PRIME_WAIT,
        ST_ROUND_GO,
        ST_ROUND_WAIT
    } mx_state_e;

endpackage

// File: rtl/modexp_mulser.sv
// Serial interleaved modular multiplier: p = a * b mod n, with b < n.
// One multiplier bit of a per clock, MSB first; done pulses once.
module modexp_mulser #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] n,
    output logic         done,
    output logic [W-1:0] p
);
    localparam int CW = $clog2(W + 1);
    localparam int XW = W + 2;

    logic [W-1:0]  a_sh;
    logic [W-1:0]  b_q;
    logic [W-1:0]  n_q;
    logic [W-1:0]  acc;
    logic [CW-1:0] cnt;
    logic          busy_q;
    logic          done_q;

    logic [XW-1:0] n_x, dbl, dbl_r, sum, sum_r;

    always_comb begin
        n_x   = {2'b00, n_q};
        dbl   = {1'b0, acc, 1'b0};
        dbl_r = (dbl >= n_x) ? dbl - n_x : dbl;
        sum   = dbl_r + (a_sh[W-1] ? {2'b00, b_q} : '0);
        sum_r = (sum >= n_x) ? sum - n_x : sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_sh   <= '0;
            b_q    <= '0;
            n_q    <= '0;
            acc    <= '0;
            cnt    <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                a_sh   <= a;
                b_q    <= b;
                n_q    <= n;
                acc    <= '0;
                cnt    <= CW'(W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                acc  <= sum_r[W-1:0];
                a_sh <= {a_sh[W-2:0], 1'b0};
                cnt  <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign p    = acc;

    assert_acc_below_mod_R10: assert property (@(posedge clk) disable iff (rst)
        (busy_q || done_q) |-> (acc < n_q));

    assert_no_restart_busy_R5: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);

endmodule

// File: rtl/modexp_expscan.sv
// Exponent scanner: LSB-first bit stream plus round index.
module modexp_expscan #(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 advance,
    input  logic [W-1:0]         e_in,
    output logic                 bit_cur,
    output logic [$clog2(W)-1:0] round_idx,
    output logic                 last
);
    localparam int RW = $clog2(W);

    logic [W-1:0]  sh;
    logic [RW-1:0] rnd;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            rnd <= '0;
        end else if (load) begin
            sh  <= e_in;
            rnd <= '0;
        end else if (advance) begin
            sh  <= {1'b0, sh[W-1:1]};
            rnd <= rnd + 1'b1;
        end
    end

    assign bit_cur   = sh[0];
    assign round_idx = rnd;
    assign last      = (rnd == RW'(W - 1));

    assert_no_extra_round_R4: assert property (@(posedge clk) disable iff (rst)
        advance |-> !last);

    assert_load_adv_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(load && advance));

endmodule

// File: rtl/modexp_engine.sv
module modexp_engine #(
    parameter int W = modexp_pkg::MX_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] mod_in,
    input  logic [W-1:0] exp_in,
    input  logic [W-1:0] data_in,
    input  logic         data_strobe,
    output logic [W-1:0] result,
    output logic         ready
);
    import modexp_pkg::*;

    localparam int RW    = $clog2(W);
    localparam int LANES = 2;

    mx_state_e state_q, state_d;

    logic [W-1:0] n_q, m_q, base_q, acc_q, result_q;

    logic [W-1:0] lane_a [LANES];
    logic [W-1:0] lane_b [LANES];
    logic [W-1:0] lane_p [LANES];
    logic [LANES-1:0] lane_start;
    logic [LANES-1:0] lane_done;

    logic          scan_load, scan_adv, bit_cur, last;
    logic [RW-1:0] round_idx;

    modexp_expscan #(.W(W)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .load      (scan_load),
        .advance   (scan_adv),
        .e_in      (exp_in),
        .bit_cur   (bit_cur),
        .round_idx (round_idx),
        .last      (last)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        modexp_mulser #(.W(W)) u_mul (
            .clk   (clk),
            .rst   (rst),
            .start (lane_start[g]),
            .a     (lane_a[g]),
            .b     (lane_b[g]),
            .n     (n_q),
            .done  (lane_done[g]),
            .p     (lane_p[g])
        );
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (data_strobe) state_d = ST_RED_GO;
            ST_RED_GO:     state_d = ST_RED_WAIT;
            ST_RED_WAIT:   if (lane_done[0]) state_d = ST_PRIME_GO;
            ST_PRIME_GO:   state_d = ST_PRIME_WAIT;
            ST_PRIME_WAIT: if (lane_done[0]) state_d = ST_ROUND_GO;
            ST_ROUND_GO:   state_d = ST_ROUND_WAIT;
            ST_ROUND_WAIT: if (lane_done[0]) state_d = last ? ST_IDLE : ST_ROUND_GO;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Outputs and lane control
    always_comb begin
        ready         = (state_q == ST_IDLE);
        lane_start[0] = (state_q == ST_RED_GO) || (state_q == ST_PRIME_GO)
                     || (state_q == ST_ROUND_GO);
        lane_start[1] = (state_q == ST_ROUND_GO);
        lane_a[0]     = (state_q == ST_RED_GO) ? m_q : base_q;
        lane_b[0]     = (state_q == ST_RED_GO) ? W'(1) : base_q;
        lane_a[1]     = acc_q;
        lane_b[1]     = base_q;
        scan_load     = (state_q == ST_IDLE) && data_strobe;
        scan_adv      = ((state_q == ST_RED_WAIT) && lane_done[0])
                     || ((state_q == ST_ROUND_WAIT) && lane_done[0] && !last);
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            n_q      <= '0;
            m_q      <= '0;
            base_q   <= '0;
            acc_q    <= '0;
            result_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (data_strobe) begin
                    n_q <= mod_in;
                    m_q <= data_in;
                end
                ST_RED_WAIT: if (lane_done[0]) begin
                    base_q <= lane_p[0];
                    acc_q  <= bit_cur ? lane_p[0] : W'(1);
                end
                ST_PRIME_WAIT: if (lane_done[0]) base_q <= lane_p[0];
                ST_ROUND_WAIT: if (lane_done[0]) begin
                    base_q <= lane_p[0];
                    if (bit_cur) acc_q <= lane_p[1];
                    if (last) result_q <= bit_cur ? lane_p[1] : acc_q;
                end
                default: ;
            endcase
        end
    end

    assign result = result_q;

    assert_ready_falls_on_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $past(data_strobe));

    assert_result_held_busy_R9: assert property (@(posedge clk) disable iff (rst)
        !ready |=> (ready || $stable(result)));

    assert_done_after_last_round_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> ($past(round_idx) == RW'(W - 1)));

    assert_lanes_in_step_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ROUND_WAIT && lane_done[0]) |-> lane_done[1]);

endmodule

// File: tb/modexp_engine_tb.sv
module modexp_engine_tb;

    typedef struct packed {
        logic [31:0] n;
        logic [31:0] e;
        logic [31:0] m;
        logic [31:0] x;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'd187,        32'd7,          32'd88,         32'd11},         // R1 encrypt
        '{32'd187,        32'd23,         32'd11,         32'd88},         // R1 decrypt
        '{32'd3233,       32'd17,         32'd65,         32'd2790},       // R1
        '{32'd3233,       32'd2753,       32'd2790,       32'd65},         // R1
        '{32'd1000003,    32'd0,          32'd12345,      32'd1},          // R2
        '{32'd10,         32'd1,          32'hFFFFFFFF,   32'd5},          // R3
        '{32'hFFFFFFFB,   32'd1,          32'hFFFFFFFF,   32'd4},          // R3
        '{32'd13,         32'd2,          32'd5,          32'd12},         // R4 bit0=0
        '{32'hFFFFFFFF,   32'h80000000,   32'd2,          32'd1},          // R4 bit31
        '{32'hFFFFFFFF,   32'hFFFFFFFF,   32'd2,          32'h80000000},   // R4
        '{32'd97,         32'd5,          32'd0,          32'd0},          // R1 zero msg
        '{32'd2,          32'hFFFFFFFF,   32'd3,          32'd1}           // R1 n=2
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mod_in = '0, exp_in = '0, data_in = '0;
    logic        data_strobe = 1'b0;
    logic [31:0] result;
    logic        ready;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int lat_ref = -1;

    always #2 clk = ~clk;   // 250 MHz

    modexp_engine u_dut (
        .clk(clk), .rst(rst), .mod_in(mod_in), .exp_in(exp_in),
        .data_in(data_in), .data_strobe(data_strobe),
        .result(result), .ready(ready)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] model_pow(input logic [31:0] n, e, m);
        longint unsigned r = 1;
        longint unsigned b = 64'(m) % 64'(n);
        for (int i = 0; i < 32; i++) begin
            if (e[i]) r = (r * b) % 64'(n);
            b = (b * b) % 64'(n);
        end
        return r[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Start an operation; optionally disturb buses and strobe while busy.
    task automatic run_op(input logic [31:0] n, e, m, input bit disturb,
                          output logic [31:0] res, output int lat);
        @(negedge clk);
        mod_in = n; exp_in = e; data_in = m; data_strobe = 1'b1;
        @(negedge clk);
        data_strobe = 1'b0;
        lat = 1;
        check("R6 ready low after strobe", 32'(ready), 32'd0);
        if (disturb) begin
            mod_in = 32'h12345679; exp_in = 32'hDEADBEEF; data_in = 32'hCAFEF00D;
        end
        while (!ready && lat < 5000) begin
            if (disturb && lat == 100) data_strobe = 1'b1;
            @(negedge clk);
            data_strobe = 1'b0;
            lat++;
        end
        res = result;
    endtask

    initial begin
        logic [31:0] r, prev;
        int lat;

        repeat (3) @(negedge clk);
        check("R8 reset result", result, 32'd0);
        check("R8 reset ready", 32'(ready), 32'd1);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].n, VECS[i].e, VECS[i].m, 1'b0, r, lat);
            check("R1 table vector", r, VECS[i].x);
            if (lat_ref < 0) lat_ref = lat;
            check("R5 latency", 32'(lat), 32'(lat_ref));
        end

        for (int i = 0; i < 16; i++) begin
            logic [31:0] n, e, m;
            n = $urandom() | 32'd3;
            e = $urandom();
            m = $urandom();
            run_op(n, e, m, 1'b0, r, lat);
            check("R1 random vs model", r, model_pow(n, e, m));
            check("R5 latency random", 32'(lat), 32'(lat_ref));
        end

        // R6/R7: buses changed and strobe pulsed mid-operation
        run_op(32'd3233, 32'd17, 32'd65, 1'b1, r, lat);
        check("R6 R7 result unaffected", r, 32'd2790);
        prev = r;
        repeat (5) @(negedge clk);
        check("R7 no queued op", 32'(ready), 32'd1);
        check("R9 result held", result, prev);

        // R9: result holds while busy
        @(negedge clk);
        mod_in = 32'd187; exp_in = 32'd7; data_in = 32'd88; data_strobe = 1'b1;
        @(negedge clk);
        data_strobe = 1'b0;
        repeat (50) @(negedge clk);
        check("R9 result stable while busy", result, prev);

        // R8: reset mid-operation
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 abort ready", 32'(ready), 32'd1);
        check("R8 abort result", result, 32'd0);
        rst = 1'b0;
        run_op(32'd1000003, 32'd1, 32'd7654321, 1'b0, r, lat);
        check("R3 after reset", r, 32'd7654321 % 32'd1000003);
        run_op(32'd99991, 32'd0, 32'd5, 1'b0, r, lat);
        check("R2 exponent zero", r, 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule